// File: doc/BRIEF.md
# Memory Module Bank Sizing Register Block

This block is the firmware-facing register set of a memory controller with six module sockets. Boot code reads it to learn which sockets are filled and whether each module is the small (8 MB) or large (32 MB) kind. It then programs an end-address table. The block turns that table into a base address and an enable for each socket, and a small decoder picks the socket that owns an incoming physical address.

Access is through byte-wide reads and writes on an ISA-style I/O bus with a 12-bit port address. Read data is driven combinationally while the read strobe is high. Side effects take place at the clock edge on which the strobe is sampled: index changes, table writes and bank placement. Socket population and module size are static configuration inputs. An auto-configure input lets the block come out of reset with every filled bank already enabled.

Top module: `simm_sizing_ctrl`

## Requirements
- R1: A read of port 0x803 returns a byte whose bit n is 1 when socket n is populated with a 32 MB module; bits 7:6 are 0.
- R2: A read of port 0x804 returns 0xFF with bit n cleared for every populated socket n.
- R3: A read of port 0x804 sets the size-table read index back to entry 0.
- R4: A read of port 0x820 returns the table entry at the read index in bits 4:0, with bits 7:5 zero, and then advances the index by one modulo 8, so entry 0 follows entry 7.
- R5: A write to port 0x820 stores data bits 4:0, an end address in 8 MB units, into the entry numbered by data bits 7:5.
- R6: On a write to entry k with 1 <= k <= 6 while socket k-1 is populated, socket k-1 gets a base equal to entry k-1 (0 when k is 1) and is enabled exactly when the written end differs from that base. Writes to entries 0 and 7 and writes for empty sockets leave every bank unchanged, and an empty socket is never enabled.
- R7: A read of port 0x841 always returns 0x01 (no parity error).
- R8: `sel_o` is one-hot for the highest-numbered enabled socket whose range [base, base + size) in 8 MB units contains `bank_seg_i` (size 1 for 8 MB, 4 for 32 MB), and `hit_o` is 1 exactly when some socket is selected. Both are all-zero on a miss.
- R9: Writes to any port other than 0x820 change no state: not the table, not the read index and not the banks. Reads of unmapped ports return 0xFF.
- R10: A synchronous reset clears the read index and all eight table entries. With `auto_cfg_i` low it also disables every bank and zeroes every base.
- R11: A reset with `auto_cfg_i` high enables every populated bank and packs the bases from 0 in socket order, each populated socket adding its size in 8 MB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | Read strobe; side effects at the sampling edge |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |
| present_i | input | 6 | Socket n populated |
| big_i | input | 6 | Socket n holds a 32 MB module (else 8 MB) |
| auto_cfg_i | input | 1 | Pack and enable banks at reset |
| bank_en_o | output | 6 | Bank enable per socket |
| bank_base_o | output | 30 | Base per socket in 8 MB units, 5 bits each, socket 0 lowest |
| bank_seg_i | input | 9 | Physical address bits 31:23 to decode |
| sel_o | output | 6 | One-hot socket select |
| hit_o | output | 1 | Some socket owns the address |

## Verification
A corrupted table entry shows up on the next 0x820 read that reaches it, and also on the next placement that uses it as a start. The placement error is visible on `bank_base_o` one clock after the write. An index that drifts or misses the presence-port reset shows as a shifted readback sequence on the very next size read. A bad enable or base appears immediately as a wrong `sel_o` for addresses near the bank edges. Overlapping ranges show whether priority goes to the highest socket.

// File: rtl/simm_ctrl_pkg.sv
package simm_ctrl_pkg;

   // which register an I/O address hits
   typedef enum logic [2:0] {
      PSEL_NONE,
      PSEL_ID,
      PSEL_PRES,
      PSEL_SIZE,
      PSEL_PAR
   } port_sel_e;

   // fixed answer of the parity status port: no error seen
   localparam logic [7:0] PARITY_OK = 8'h01;

endpackage

// File: rtl/simm_end_table.sv
module simm_end_table #(
   parameter int NUM_SOCKETS = 6,
   parameter int IDX_W       = 3,
   parameter int END_W       = 5,
   localparam int NUM_ENTRIES = 1 << IDX_W,
   localparam int DATA_W      = IDX_W + END_W
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_adv,
   input  logic                         rd_clr,
   output logic [END_W-1:0]             rd_val,
   output logic [NUM_SOCKETS*END_W-1:0] start_flat
);

   logic [END_W-1:0] ent_q [NUM_ENTRIES];
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
         for (int e = 0; e < NUM_ENTRIES; e++) ent_q[e] <= '0;
      end else begin
         if (wr_en) ent_q[wr_data[DATA_W-1:END_W]] <= wr_data[END_W-1:0];
         if (rd_clr)      idx_q <= '0;
         else if (rd_adv) idx_q <= idx_q + 1'b1;
      end
   end

   assign rd_val = ent_q[idx_q];

   // start of socket s is entry s, except socket 0 which starts at 0
   for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_start
      if (s == 0) begin : g_first
         assign start_flat[s*END_W +: END_W] = '0;
      end else begin : g_rest
         assign start_flat[s*END_W +: END_W] = ent_q[s];
      end
   end

endmodule

// File: rtl/simm_bank_place.sv
module simm_bank_place #(
   parameter int NUM_SOCKETS = 6,
   parameter int IDX_W       = 3,
   parameter int END_W       = 5,
   parameter int SMALL_UNITS = 1,
   parameter int BIG_UNITS   = 4,
   localparam int DATA_W     = IDX_W + END_W
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         auto_cfg,
   input  logic [NUM_SOCKETS-1:0]       present,
   input  logic [NUM_SOCKETS-1:0]       big,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [NUM_SOCKETS*END_W-1:0] start_flat,
   output logic [NUM_SOCKETS-1:0]       bank_en,
   output logic [NUM_SOCKETS*END_W-1:0] bank_base
);

   logic [END_W-1:0] pack_base [NUM_SOCKETS];
   logic [END_W-1:0] acc;
   logic [IDX_W-1:0] wr_k;
   logic [END_W-1:0] wr_end;

   assign wr_k   = wr_data[DATA_W-1:END_W];
   assign wr_end = wr_data[END_W-1:0];

   // contiguous packing used by auto-configure
   always_comb begin
      acc = '0;
      for (int s = 0; s < NUM_SOCKETS; s++) begin
         pack_base[s] = acc;
         if (present[s])
            acc = acc + (big[s] ? END_W'(BIG_UNITS) : END_W'(SMALL_UNITS));
      end
   end

   for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
      logic             place;
      logic [END_W-1:0] start;
      logic             en_q;
      logic [END_W-1:0] base_q;

      assign start = start_flat[s*END_W +: END_W];
      assign place = wr_en && (wr_k == IDX_W'(s + 1)) && present[s];

      always_ff @(posedge clk) begin
         if (rst) begin
            en_q   <= auto_cfg & present[s];
            base_q <= (auto_cfg && present[s]) ? pack_base[s] : '0;
         end else if (place) begin
            en_q   <= (wr_end != start);
            base_q <= start;
         end
      end

      assign bank_en[s]                   = en_q;
      assign bank_base[s*END_W +: END_W]  = base_q;
   end

endmodule

// File: rtl/simm_bank_decode.sv
module simm_bank_decode #(
   parameter int NUM_SOCKETS = 6,
   parameter int END_W       = 5,
   parameter int SEG_W       = 9,
   parameter int SMALL_UNITS = 1,
   parameter int BIG_UNITS   = 4,
   localparam int PAD        = SEG_W + 1 - END_W
) (
   input  logic [NUM_SOCKETS-1:0]       bank_en,
   input  logic [NUM_SOCKETS-1:0]       big,
   input  logic [NUM_SOCKETS*END_W-1:0] bank_base,
   input  logic [SEG_W-1:0]             seg,
   output logic [NUM_SOCKETS-1:0]       sel,
   output logic                         hit
);

   logic [NUM_SOCKETS-1:0] cand;
   logic [SEG_W:0]         seg_x;

   assign seg_x = {1'b0, seg};

   for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_rng
      logic [SEG_W:0] lo;
      logic [SEG_W:0] hi;
      assign lo = {{PAD{1'b0}}, bank_base[s*END_W +: END_W]};
      assign hi = lo + (big[s] ? (SEG_W+1)'(BIG_UNITS) : (SEG_W+1)'(SMALL_UNITS));
      assign cand[s] = bank_en[s] && (seg_x >= lo) && (seg_x < hi);
   end

   // later sockets override earlier ones: highest number wins
   always_comb begin
      sel = '0;
      for (int s = 0; s < NUM_SOCKETS; s++) begin
         if (cand[s]) begin
            sel    = '0;
            sel[s] = 1'b1;
         end
      end
   end

   assign hit = |cand;

endmodule

// File: rtl/simm_sizing_ctrl.sv
module simm_sizing_ctrl
   import simm_ctrl_pkg::*;
#(
   parameter int NUM_SOCKETS = 6,
   parameter int IDX_W       = 3,
   parameter int END_W       = 5,
   parameter int IO_AW       = 12,
   parameter int ADDR_W      = 32,
   parameter int UNIT_LOG2   = 23,
   parameter int SMALL_UNITS = 1,
   parameter int BIG_UNITS   = 4,
   parameter logic [IO_AW-1:0] PORT_ID   = 12'h803,
   parameter logic [IO_AW-1:0] PORT_PRES = 12'h804,
   parameter logic [IO_AW-1:0] PORT_SIZE = 12'h820,
   parameter logic [IO_AW-1:0] PORT_PAR  = 12'h841,
   localparam int NUM_ENTRIES = 1 << IDX_W,
   localparam int DATA_W      = IDX_W + END_W,
   localparam int SEG_W       = ADDR_W - UNIT_LOG2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [IO_AW-1:0]             io_addr,
   input  logic                         io_rd,
   input  logic                         io_wr,
   input  logic [DATA_W-1:0]            io_wdata,
   output logic [DATA_W-1:0]            io_rdata,
   input  logic [NUM_SOCKETS-1:0]       present_i,
   input  logic [NUM_SOCKETS-1:0]       big_i,
   input  logic                         auto_cfg_i,
   output logic [NUM_SOCKETS-1:0]       bank_en_o,
   output logic [NUM_SOCKETS*END_W-1:0] bank_base_o,
   input  logic [SEG_W-1:0]             bank_seg_i,
   output logic [NUM_SOCKETS-1:0]       sel_o,
   output logic                         hit_o
);

   // elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_data_w
      $error("entry number plus end address must fill one byte");
   end
   if (NUM_SOCKETS + 1 > NUM_ENTRIES) begin : g_bad_entries
      $error("table needs one entry per socket plus entry 0");
   end
   if (NUM_SOCKETS > DATA_W) begin : g_bad_bitmap
      $error("socket bitmaps must fit a data byte");
   end
   if (SEG_W < END_W) begin : g_bad_seg
      $error("decoded address segment narrower than base field");
   end

   port_sel_e              psel;
   logic [END_W-1:0]       rd_val;
   logic [NUM_SOCKETS*END_W-1:0] start_flat;
   logic                   size_wr;

   always_comb begin
      unique case (io_addr)
         PORT_ID:   psel = PSEL_ID;
         PORT_PRES: psel = PSEL_PRES;
         PORT_SIZE: psel = PSEL_SIZE;
         PORT_PAR:  psel = PSEL_PAR;
         default:   psel = PSEL_NONE;
      endcase
   end

   assign size_wr = io_wr && (psel == PSEL_SIZE);

   simm_end_table #(
      .NUM_SOCKETS(NUM_SOCKETS), .IDX_W(IDX_W), .END_W(END_W)
   ) i_table (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (size_wr),
      .wr_data   (io_wdata),
      .rd_adv    (io_rd && (psel == PSEL_SIZE)),
      .rd_clr    (io_rd && (psel == PSEL_PRES)),
      .rd_val    (rd_val),
      .start_flat(start_flat)
   );

   simm_bank_place #(
      .NUM_SOCKETS(NUM_SOCKETS), .IDX_W(IDX_W), .END_W(END_W),
      .SMALL_UNITS(SMALL_UNITS), .BIG_UNITS(BIG_UNITS)
   ) i_place (
      .clk       (clk),
      .rst       (rst),
      .auto_cfg  (auto_cfg_i),
      .present   (present_i),
      .big       (big_i),
      .wr_en     (size_wr),
      .wr_data   (io_wdata),
      .start_flat(start_flat),
      .bank_en   (bank_en_o),
      .bank_base (bank_base_o)
   );

   simm_bank_decode #(
      .NUM_SOCKETS(NUM_SOCKETS), .END_W(END_W), .SEG_W(SEG_W),
      .SMALL_UNITS(SMALL_UNITS), .BIG_UNITS(BIG_UNITS)
   ) i_decode (
      .bank_en  (bank_en_o),
      .big      (big_i),
      .bank_base(bank_base_o),
      .seg      (bank_seg_i),
      .sel      (sel_o),
      .hit      (hit_o)
   );

   always_comb begin
      io_rdata = '1;
      case (psel)
         PSEL_ID: begin
            io_rdata = '0;
            io_rdata[NUM_SOCKETS-1:0] = big_i & present_i;
         end
         PSEL_PRES: io_rdata[NUM_SOCKETS-1:0] = ~present_i;
         PSEL_SIZE: io_rdata = DATA_W'(rd_val);
         PSEL_PAR:  io_rdata = PARITY_OK;
         default:   io_rdata = '1;
      endcase
   end

endmodule

// File: rtl/simm_sizing_ctrl_chk.sv
module simm_sizing_ctrl_chk #(
   parameter int NUM_SOCKETS = 6,
   parameter int IDX_W       = 3,
   parameter int END_W       = 5,
   parameter int IO_AW       = 12,
   parameter logic [IO_AW-1:0] PORT_SIZE = 12'h820,
   parameter logic [IO_AW-1:0] PORT_PAR  = 12'h841,
   localparam int DATA_W = IDX_W + END_W
) (
   input logic                         clk,
   input logic                         rst,
   input logic [IO_AW-1:0]             io_addr,
   input logic                         io_rd,
   input logic                         io_wr,
   input logic [DATA_W-1:0]            io_wdata,
   input logic [DATA_W-1:0]            io_rdata,
   input logic [NUM_SOCKETS-1:0]       present_i,
   input logic                         auto_cfg_i,
   input logic [NUM_SOCKETS-1:0]       bank_en_o,
   input logic [NUM_SOCKETS*END_W-1:0] bank_base_o,
   input logic [NUM_SOCKETS-1:0]       sel_o,
   input logic                         hit_o
);

   logic [IDX_W-1:0] wk;
   assign wk = io_wdata[DATA_W-1:END_W];

   p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_o));

   p_sel_enabled_r8: assert property (@(posedge clk) disable iff (rst)
      (sel_o & ~bank_en_o) == '0);

   p_hit_matches_sel_r8: assert property (@(posedge clk) disable iff (rst)
      hit_o == (sel_o != '0));

   p_parity_ok_r7: assert property (@(posedge clk) disable iff (rst)
      (io_rd && io_addr == PORT_PAR) |-> io_rdata == 8'h01);

   p_size_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (io_rd && io_addr == PORT_SIZE) |-> io_rdata[DATA_W-1:END_W] == '0);

   p_empty_off_r6: assert property (@(posedge clk) disable iff (rst)
      (bank_en_o & ~present_i) == '0);

   p_outer_entry_r6: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr == PORT_SIZE && (wk == '0 || int'(wk) > NUM_SOCKETS))
      |=> ($stable(bank_en_o) && $stable(bank_base_o)));

   p_ro_write_r9: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_addr != PORT_SIZE)
      |=> ($stable(bank_en_o) && $stable(bank_base_o)));

   p_manual_reset_r10: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !$past(auto_cfg_i)) |-> (bank_en_o == '0 && bank_base_o == '0));

   p_auto_reset_r11: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && $past(auto_cfg_i)) |-> bank_en_o == present_i);

endmodule

bind simm_sizing_ctrl simm_sizing_ctrl_chk #(
   .NUM_SOCKETS(NUM_SOCKETS), .IDX_W(IDX_W), .END_W(END_W), .IO_AW(IO_AW),
   .PORT_SIZE(PORT_SIZE), .PORT_PAR(PORT_PAR)
) i_chk (
   .clk        (clk),
   .rst        (rst),
   .io_addr    (io_addr),
   .io_rd      (io_rd),
   .io_wr      (io_wr),
   .io_wdata   (io_wdata),
   .io_rdata   (io_rdata),
   .present_i  (present_i),
   .auto_cfg_i (auto_cfg_i),
   .bank_en_o  (bank_en_o),
   .bank_base_o(bank_base_o),
   .sel_o      (sel_o),
   .hit_o      (hit_o)
);

// File: tb/test_simm_sizing_ctrl.sv
`timescale 1ns/1ps
module test_simm_sizing_ctrl;

   logic        clk = 1'b0;
   logic        rst;
   logic [11:0] io_addr;
   logic        io_rd, io_wr;
   logic [7:0]  io_wdata, io_rdata;
   logic [5:0]  present_i, big_i;
   logic        auto_cfg_i;
   logic [5:0]  bank_en_o;
   logic [29:0] bank_base_o;
   logic [8:0]  bank_seg_i;
   logic [5:0]  sel_o;
   logic        hit_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   simm_sizing_ctrl i_simm_sizing_ctrl (
      .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .present_i(present_i),
      .big_i(big_i), .auto_cfg_i(auto_cfg_i), .bank_en_o(bank_en_o),
      .bank_base_o(bank_base_o), .bank_seg_i(bank_seg_i), .sel_o(sel_o),
      .hit_o(hit_o)
   );

   localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_DEC = 2'd2;
   localparam int NV = 42;
   // {req, op, port, data, expected}; decode: data = segment, exp = {0,hit,sel}
   localparam logic [33:0] VEC [NV] = '{
      {4'd1,  OP_RD,  12'h803, 8'h00, 8'h03},  // R1 id bitmap
      {4'd2,  OP_RD,  12'h804, 8'h00, 8'hF0},  // R2 presence
      {4'd7,  OP_RD,  12'h841, 8'h00, 8'h01},  // R7 parity
      {4'd9,  OP_RD,  12'h900, 8'h00, 8'hFF},  // R9 unmapped
      {4'd5,  OP_WR,  12'h820, 8'h24, 8'h00},  // R5 entry1=4
      {4'd5,  OP_WR,  12'h820, 8'h48, 8'h00},  // entry2=8
      {4'd5,  OP_WR,  12'h820, 8'h69, 8'h00},  // entry3=9
      {4'd5,  OP_WR,  12'h820, 8'h8A, 8'h00},  // entry4=10
      {4'd6,  OP_WR,  12'h820, 8'hAA, 8'h00},  // R6 entry5, socket4 empty
      {4'd8,  OP_DEC, 12'h000, 8'h00, 8'h41},  // R8
      {4'd8,  OP_DEC, 12'h000, 8'h05, 8'h42},
      {4'd8,  OP_DEC, 12'h000, 8'h08, 8'h44},
      {4'd8,  OP_DEC, 12'h000, 8'h09, 8'h48},
      {4'd8,  OP_DEC, 12'h000, 8'h0A, 8'h00},  // miss
      {4'd3,  OP_RD,  12'h804, 8'h00, 8'hF0},  // R3 index reset
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h00},  // R4 walk
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h04},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h08},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h09},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h0A},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h0A},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h00},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h00},
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h00},  // wrapped to entry0
      {4'd4,  OP_RD,  12'h820, 8'h00, 8'h04},
      {4'd9,  OP_WR,  12'h804, 8'h00, 8'h00},  // R9 ignored writes
      {4'd9,  OP_WR,  12'h803, 8'h00, 8'h00},
      {4'd9,  OP_RD,  12'h820, 8'h00, 8'h08},  // index untouched
      {4'd9,  OP_DEC, 12'h000, 8'h00, 8'h41},
      {4'd6,  OP_WR,  12'h820, 8'h44, 8'h00},  // R6 end==start
      {4'd6,  OP_DEC, 12'h000, 8'h05, 8'h00},
      {4'd6,  OP_WR,  12'h820, 8'h22, 8'h00},
      {4'd6,  OP_WR,  12'h820, 8'h4C, 8'h00},
      {4'd8,  OP_DEC, 12'h000, 8'h03, 8'h42},  // overlap, higher wins
      {4'd8,  OP_DEC, 12'h000, 8'h01, 8'h41},
      {4'd6,  OP_WR,  12'h820, 8'hFF, 8'h00},  // entry7: no placement
      {4'd6,  OP_WR,  12'h820, 8'h03, 8'h00},  // entry0: no placement
      {4'd6,  OP_DEC, 12'h000, 8'h09, 8'h48},
      {4'd6,  OP_DEC, 12'h000, 8'h08, 8'h44},
      {4'd5,  OP_RD,  12'h804, 8'h00, 8'hF0},
      {4'd5,  OP_RD,  12'h820, 8'h00, 8'h03},
      {4'd5,  OP_RD,  12'h820, 8'h00, 8'h02}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic auto);
      @(negedge clk);
      auto_cfg_i = auto;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #5 d = io_rdata;
      @(posedge clk);
      #1 io_rd = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk);
      #1 io_wr = 1'b0;
   endtask

   task automatic dec(input logic [8:0] seg, output logic [7:0] r);
      @(negedge clk);
      bank_seg_i = seg;
      #5 r = {1'b0, hit_o, sel_o};
   endtask

   initial begin
      logic [7:0]  d;
      logic [29:0] exp_base;
      logic [4:0]  acc;
      io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0; bank_seg_i = '0;
      present_i = 6'b001111; big_i = 6'b000011; auto_cfg_i = 0; rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;

      // R10 reset state
      #5 check("R10 en", 32'(bank_en_o), 0);
      check("R10 base", 32'(bank_base_o), 0);
      rd(12'h820, d); check("R10 entry0", 32'(d), 0);
      dec(9'd0, d); check("R10 no hit", 32'(d), 0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] r;
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][33:30], i);
         case (VEC[i][29:28])
            OP_RD: begin rd(VEC[i][27:16], r); check(tag, 32'(r), 32'(VEC[i][7:0])); end
            OP_WR: wr(VEC[i][27:16], VEC[i][15:8]);
            default: begin dec({1'b0, VEC[i][15:8]}, r); check(tag, 32'(r), 32'(VEC[i][7:0])); end
         endcase
      end

      // R11 auto-configure reset: packed in socket order
      do_reset(1'b1);
      #5;
      acc = '0; exp_base = '0;
      for (int s = 0; s < 6; s++) begin
         if (present_i[s]) begin
            exp_base[s*5 +: 5] = acc;
            acc = acc + (big_i[s] ? 5'd4 : 5'd1);
         end
      end
      check("R11 en", 32'(bank_en_o), 32'(present_i));
      check("R11 base", 32'(bank_base_o), 32'(exp_base));
      dec(9'd4, d); check("R11 dec socket1", 32'(d), 32'h42);
      dec(9'd9, d); check("R11 dec socket3", 32'(d), 32'h48);
      rd(12'h820, d); check("R10 cleared after auto", 32'(d), 0);
      rd(12'h820, d); check("R10 entry1 cleared", 32'(d), 0);

      // R10 manual reset disables banks
      do_reset(1'b0);
      #5 check("R10 en manual", 32'(bank_en_o), 0);
      dec(9'd0, d); check("R10 dec miss", 32'(d), 0);

      // R1, R2 with another population
      present_i = 6'b111111; big_i = 6'b110011;
      rd(12'h803, d); check("R1 id", 32'(d), 32'h33);
      rd(12'h804, d); check("R2 presence", 32'(d), 32'hC0);
      present_i = 6'b110000; big_i = 6'b111111;
      rd(12'h803, d); check("R1 id masked", 32'(d), 32'h30);
      rd(12'h804, d); check("R2 presence sparse", 32'(d), 32'hCF);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule